// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block performs the entry steps of a real-mode hardware interrupt or software interrupt for a 16-bit segmented core. On a start pulse it captures the vector number, the interrupt table base and limit, the current flags, code selector, instruction pointer, stack pointer, stack base and code limit. It then runs a fixed sequence of word accesses on a single memory port. First it checks the table bound. Then it saves the return frame on the stack. Then it reads the handler pointer from the table.

The memory port carries one request at a time under a valid/ready handshake. A read returns its data in the cycle the request is accepted. When the sequence finishes, the block pulses a completion strobe and presents the new code selector, the new code base, the new instruction pointer, the new stack pointer and the new flags. When a check fails, it pulses a fault strobe with a general-protection code instead and does not complete the load.

Top module: `rmint_seq`

## Requirements
- R1: When vector*4+3 is greater than the table limit, the block pulses `fault_o` with `fault_code_o` = 13 and `fault_err_o` = 0. In that case it issues no memory request at all.
- R2: The return frame is written as three word writes in this order: the low 16 bits of the flags, then the current code selector, then the current instruction pointer. Each write goes to stack base + (SP − 2), with SP decremented by 2 before each write and wrapping modulo 2^16.
- R3: After the writes, the block reads the new instruction pointer from table base + 4*vector. It then reads the new code selector from table base + 4*vector + 2, in that order.
- R4: When the fetched instruction pointer is greater than the code limit, the block pulses `fault_o` (code 13, error 0). It issues no selector read, and `new_cs_o` keeps its previous value.
- R5: On success the block pulses `done_o` for one cycle. At that point `new_cs_o` is the fetched selector, `new_cs_base_o` is the selector shifted left by 4, `new_ip_o` is the fetched pointer zero-extended to 32 bits, and `new_sp_o` is the entry SP minus 6 (mod 2^16).
- R6: `new_flags_o` equals the entry flags with bit 9 (interrupt enable), bit 8 (trap), and bit 16 (resume) cleared. Bit 18 (alignment check) is also cleared when CORE_LEVEL >= 4. All other bits are unchanged.
- R7: While a request is not accepted, `mem_req_o` stays high, and the address, write enable and write data stay stable.
- R8: A start pulse that arrives while `busy_o` is high is ignored; the running sequence and its results are unaffected.
- R9: After reset, `busy_o`, `mem_req_o`, `done_o` and `fault_o` are low.
- R10: `done_o` and `fault_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an interrupt entry |
| vec_i | input | 8 | Interrupt vector number |
| tbl_base_i | input | ADDR_W | Interrupt table base address |
| tbl_limit_i | input | 16 | Interrupt table limit |
| flags_i | input | 32 | Current flags |
| cs_sel_i | input | 16 | Current code selector |
| ip_i | input | 16 | Current instruction pointer |
| sp_i | input | 16 | Current stack pointer |
| ss_base_i | input | ADDR_W | Stack segment base |
| cs_limit_i | input | 32 | Code segment scaled limit |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Request byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_ready_i | input | 1 | Request accepted this cycle |
| mem_rdata_i | input | 16 | Read data, valid when accepted |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Successful completion pulse |
| fault_o | output | 1 | Fault pulse |
| fault_code_o | output | 8 | Fault vector (13) |
| fault_err_o | output | 16 | Fault error code (0) |
| new_ip_o | output | 32 | New instruction pointer |
| new_cs_o | output | 16 | New code selector |
| new_cs_base_o | output | ADDR_W | New code base |
| new_sp_o | output | 16 | Stack pointer after the frame |
| new_flags_o | output | 32 | Flags after entry |

## Verification
The sequence is driven with vectors that sit just inside and just outside the table bound. This separates the bound fault, which makes no accesses, from a full entry. A stack pointer near zero shows whether the push addresses wrap modulo 2^16. Code limits one below and equal to the fetched pointer separate the late fault, which saves the frame but does not read the selector, from a completion. Entry flags with every bit set show that exactly the four named bits are cleared. The memory stalls in a pseudo-random pattern, and a second start is sent during a run; together these expose any request that drops early and any restart that corrupts the run.

// File: rtl/rmint_pkg.sv
// Shared types and constants for the real-mode interrupt entry sequencer.
// Assumes the conventional flag bit layout of a 16/32-bit segmented core.
package rmint_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CHECK   = 3'd1,
        ST_PUSH_FL = 3'd2,
        ST_PUSH_CS = 3'd3,
        ST_PUSH_IP = 3'd4,
        ST_RD_IP   = 3'd5,
        ST_RD_CS   = 3'd6
    } seq_state_t;

    localparam logic [7:0] FAULT_GP   = 8'd13;
    localparam int         FLG_TRAP   = 8;
    localparam int         FLG_INTEN  = 9;
    localparam int         FLG_RESUME = 16;
    localparam int         FLG_ALIGN  = 18;
endpackage

// File: rtl/rmint_addr_gen.sv
// Address generator: forms the memory address for the current sequencer step.
// Assumes pushes use a pre-decremented 16-bit SP and table entries are 4 bytes.
module rmint_addr_gen
    import rmint_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  seq_state_t        st,
    input  logic [ADDR_W-1:0] ss_base,
    input  logic [15:0]       sp,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [7:0]        vec,
    output logic [ADDR_W-1:0] addr
);
    logic [15:0]       sp_dec;
    logic [ADDR_W-1:0] entry;

    // Select stack slot or table entry word for the active step
    always_comb begin
        sp_dec = sp - 16'd2;
        entry  = tbl_base + ADDR_W'({vec, 2'b00});
        case (st)
            ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP: addr = ss_base + ADDR_W'(sp_dec);
            ST_RD_IP:                           addr = entry;
            ST_RD_CS:                           addr = entry + ADDR_W'(2);
            default:                            addr = '0;
        endcase
    end
endmodule

// File: rtl/rmint_flag_upd.sv
// Flag update: clears the entry-affected flag bits.
// The alignment-check bit is cleared only on cores of level 4 and up.
module rmint_flag_upd
    import rmint_pkg::*;
#(
    parameter int CORE_LEVEL = 4
) (
    input  logic [31:0] flags_in,
    output logic [31:0] flags_out
);
    logic [31:0] clr_mask;

    generate
        if (CORE_LEVEL >= 4) begin : g_with_ac
            // Mask including alignment check
            always_comb begin
                clr_mask = '0;
                clr_mask[FLG_TRAP]   = 1'b1;
                clr_mask[FLG_INTEN]  = 1'b1;
                clr_mask[FLG_RESUME] = 1'b1;
                clr_mask[FLG_ALIGN]  = 1'b1;
            end
        end else begin : g_no_ac
            // Mask without alignment check
            always_comb begin
                clr_mask = '0;
                clr_mask[FLG_TRAP]   = 1'b1;
                clr_mask[FLG_INTEN]  = 1'b1;
                clr_mask[FLG_RESUME] = 1'b1;
            end
        end
    endgenerate

    assign flags_out = flags_in & ~clr_mask;
endmodule

// File: rtl/rmint_seq.sv
// Real-mode interrupt entry sequencer (top).
// Captures the entry context on start. It checks the table bound, pushes
// the flags, CS and IP, reads the handler IP and checks it against the CS
// limit, then reads CS. It ends with a done or a fault pulse.
// Assumes the memory returns read data in the cycle it asserts ready.
module rmint_seq
    import rmint_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int CORE_LEVEL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        vec_i,
    input  logic [ADDR_W-1:0] tbl_base_i,
    input  logic [15:0]       tbl_limit_i,
    input  logic [31:0]       flags_i,
    input  logic [15:0]       cs_sel_i,
    input  logic [15:0]       ip_i,
    input  logic [15:0]       sp_i,
    input  logic [ADDR_W-1:0] ss_base_i,
    input  logic [31:0]       cs_limit_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [15:0]       mem_wdata_o,
    input  logic              mem_ready_i,
    input  logic [15:0]       mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fault_o,
    output logic [7:0]        fault_code_o,
    output logic [15:0]       fault_err_o,
    output logic [31:0]       new_ip_o,
    output logic [15:0]       new_cs_o,
    output logic [ADDR_W-1:0] new_cs_base_o,
    output logic [15:0]       new_sp_o,
    output logic [31:0]       new_flags_o
);
    seq_state_t        st;
    logic [7:0]        vec_r;
    logic [ADDR_W-1:0] tbl_base_r;
    logic [15:0]       tbl_lim_r;
    logic [31:0]       flags_r;
    logic [15:0]       cs_r;
    logic [15:0]       ip_r;
    logic [15:0]       sp_r;
    logic [ADDR_W-1:0] ss_base_r;
    logic [31:0]       cs_lim_r;
    logic [15:0]       ip_new_r;
    logic [31:0]       flags_upd;
    logic              is_push;
    logic              is_read;
    logic              tbl_ok;

    // Address mux for stack and table accesses
    rmint_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .st       (st),
        .ss_base  (ss_base_r),
        .sp       (sp_r),
        .tbl_base (tbl_base_r),
        .vec      (vec_r),
        .addr     (mem_addr_o)
    );

    // Entry flag clearing
    rmint_flag_upd #(.CORE_LEVEL(CORE_LEVEL)) u_flags (
        .flags_in  (flags_r),
        .flags_out (flags_upd)
    );

    // Decode step class and table bound
    always_comb begin
        is_push = (st == ST_PUSH_FL) || (st == ST_PUSH_CS) || (st == ST_PUSH_IP);
        is_read = (st == ST_RD_IP) || (st == ST_RD_CS);
        tbl_ok  = ({6'd0, vec_r, 2'b11} <= tbl_lim_r);
    end

    assign mem_req_o = is_push || is_read;
    assign mem_we_o  = is_push;
    assign busy_o    = (st != ST_IDLE);

    // Select the word pushed in each push step
    always_comb begin
        case (st)
            ST_PUSH_FL: mem_wdata_o = flags_r[15:0];
            ST_PUSH_CS: mem_wdata_o = cs_r;
            ST_PUSH_IP: mem_wdata_o = ip_r;
            default:    mem_wdata_o = 16'd0;
        endcase
    end

    // Sequencer state, context capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st            <= ST_IDLE;
            vec_r         <= '0;
            tbl_base_r    <= '0;
            tbl_lim_r     <= '0;
            flags_r       <= '0;
            cs_r          <= '0;
            ip_r          <= '0;
            sp_r          <= '0;
            ss_base_r     <= '0;
            cs_lim_r      <= '0;
            ip_new_r      <= '0;
            done_o        <= 1'b0;
            fault_o       <= 1'b0;
            fault_code_o  <= '0;
            fault_err_o   <= '0;
            new_ip_o      <= '0;
            new_cs_o      <= '0;
            new_cs_base_o <= '0;
            new_sp_o      <= '0;
            new_flags_o   <= '0;
        end else begin
            done_o  <= 1'b0;
            fault_o <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        vec_r      <= vec_i;
                        tbl_base_r <= tbl_base_i;
                        tbl_lim_r  <= tbl_limit_i;
                        flags_r    <= flags_i;
                        cs_r       <= cs_sel_i;
                        ip_r       <= ip_i;
                        sp_r       <= sp_i;
                        ss_base_r  <= ss_base_i;
                        cs_lim_r   <= cs_limit_i;
                        st         <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!tbl_ok) begin
                        fault_o      <= 1'b1;
                        fault_code_o <= FAULT_GP;
                        fault_err_o  <= 16'd0;
                        st           <= ST_IDLE;
                    end else begin
                        st <= ST_PUSH_FL;
                    end
                end
                ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP: begin
                    if (mem_ready_i) begin
                        sp_r <= sp_r - 16'd2;
                        st   <= (st == ST_PUSH_FL) ? ST_PUSH_CS :
                                (st == ST_PUSH_CS) ? ST_PUSH_IP : ST_RD_IP;
                    end
                end
                ST_RD_IP: begin
                    if (mem_ready_i) begin
                        ip_new_r <= mem_rdata_i;
                        if ({16'd0, mem_rdata_i} > cs_lim_r) begin
                            fault_o      <= 1'b1;
                            fault_code_o <= FAULT_GP;
                            fault_err_o  <= 16'd0;
                            st           <= ST_IDLE;
                        end else begin
                            st <= ST_RD_CS;
                        end
                    end
                end
                ST_RD_CS: begin
                    if (mem_ready_i) begin
                        new_cs_o      <= mem_rdata_i;
                        new_cs_base_o <= ADDR_W'({mem_rdata_i, 4'd0});
                        new_ip_o      <= {16'd0, ip_new_r};
                        new_sp_o      <= sp_r;
                        new_flags_o   <= flags_upd;
                        done_o        <= 1'b1;
                        st            <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R1
    tbl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CHECK && !tbl_ok) |=> (fault_o && !mem_req_o));

    // R2
    sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_push && mem_ready_i) |=> (sp_r == $past(sp_r) - 16'd2));

    // R4
    ip_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (new_ip_o[31:16] == 16'd0 && new_ip_o <= cs_lim_r));

    // R1 / R4 fault payload
    fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (fault_code_o == FAULT_GP && fault_err_o == 16'd0));

    // R7
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
            && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(vec_r) && $stable(sp_r) || $past(is_push)));

    // R10
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fault_o));
endmodule

// File: tb/test_rmint_seq.sv
module test_rmint_seq;
    localparam int ADDR_W = 24;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       data;
    } xact_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [7:0] vec_i = '0;
    logic [ADDR_W-1:0] tbl_base_i = '0;
    logic [15:0] tbl_limit_i = '0;
    logic [31:0] flags_i = '0;
    logic [15:0] cs_sel_i = '0, ip_i = '0, sp_i = '0;
    logic [ADDR_W-1:0] ss_base_i = '0;
    logic [31:0] cs_limit_i = '0;
    logic mem_req_o, mem_we_o, mem_ready_i;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [15:0] mem_wdata_o, mem_rdata_i;
    logic busy_o, done_o, fault_o;
    logic [7:0] fault_code_o;
    logic [15:0] fault_err_o;
    logic [31:0] new_ip_o;
    logic [15:0] new_cs_o;
    logic [ADDR_W-1:0] new_cs_base_o;
    logic [15:0] new_sp_o;
    logic [31:0] new_flags_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    xact_t exp_q[$];
    logic [7:0] lfsr = 8'hA5;
    logic stall_mode = 1'b1;
    logic prev_stall = 1'b0;
    logic [ADDR_W-1:0] prev_addr = '0;
    logic [15:0] last_cs = '0;

    function automatic logic [15:0] rd_fn(input logic [ADDR_W-1:0] a);
        return a[15:0] ^ {a[23:16], 8'h00} ^ 16'h1357;
    endfunction

    assign mem_rdata_i = rd_fn(mem_addr_o);

    rmint_seq #(.ADDR_W(ADDR_W), .CORE_LEVEL(4)) i_rmint_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vec_i(vec_i),
        .tbl_base_i(tbl_base_i), .tbl_limit_i(tbl_limit_i), .flags_i(flags_i),
        .cs_sel_i(cs_sel_i), .ip_i(ip_i), .sp_i(sp_i), .ss_base_i(ss_base_i),
        .cs_limit_i(cs_limit_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i),
        .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
        .fault_code_o(fault_code_o), .fault_err_o(fault_err_o), .new_ip_o(new_ip_o),
        .new_cs_o(new_cs_o), .new_cs_base_o(new_cs_base_o), .new_sp_o(new_sp_o),
        .new_flags_o(new_flags_o)
    );

    initial mem_ready_i = 1'b0;
    always #2 clk = ~clk;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model and scoreboard monitor
    always @(negedge clk) begin
        xact_t e;
        if (prev_stall)
            chk(mem_req_o && mem_addr_o == prev_addr, "R7 request held", {8'd0, mem_addr_o}, {8'd0, prev_addr});
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready_i = stall_mode ? (lfsr[0] | lfsr[1]) : 1'b1;
        prev_stall = mem_req_o && !mem_ready_i;
        prev_addr = mem_addr_o;
        if (mem_req_o && mem_ready_i) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1/R4 unexpected access", {8'd0, mem_addr_o}, 32'hFFFFFFFF);
            end else begin
                e = exp_q.pop_front();
                chk(mem_we_o == e.we && mem_addr_o == e.addr, "R2/R3 access order",
                    {7'd0, mem_we_o, mem_addr_o}, {7'd0, e.we, e.addr});
                if (e.we)
                    chk(mem_wdata_o == e.data, "R2 push data", {16'd0, mem_wdata_o}, {16'd0, e.data});
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_case(input logic [7:0] v, input logic [ADDR_W-1:0] base, input logic [15:0] lim,
                            input logic [31:0] fl, input logic [15:0] cs, input logic [15:0] ip,
                            input logic [15:0] sp, input logic [ADDR_W-1:0] ssb, input logic [31:0] cslim,
                            input logic second_start);
        logic lim_fault, ip_fault, seen_done, seen_fault;
        logic [15:0] s, ipv, csv;
        logic [ADDR_W-1:0] ent;
        lim_fault = ({6'd0, v, 2'b11} > lim);
        ent = base + ADDR_W'({v, 2'b00});
        ipv = rd_fn(ent);
        csv = rd_fn(ent + ADDR_W'(2));
        ip_fault = !lim_fault && ({16'd0, ipv} > cslim);
        s = sp;
        if (!lim_fault) begin
            s = s - 16'd2; exp_q.push_back('{1'b1, ssb + ADDR_W'(s), fl[15:0]});
            s = s - 16'd2; exp_q.push_back('{1'b1, ssb + ADDR_W'(s), cs});
            s = s - 16'd2; exp_q.push_back('{1'b1, ssb + ADDR_W'(s), ip});
            exp_q.push_back('{1'b0, ent, 16'd0});
            if (!ip_fault) exp_q.push_back('{1'b0, ent + ADDR_W'(2), 16'd0});
        end
        @(negedge clk);
        vec_i = v; tbl_base_i = base; tbl_limit_i = lim; flags_i = fl; cs_sel_i = cs;
        ip_i = ip; sp_i = sp; ss_base_i = ssb; cs_limit_i = cslim; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        seen_done = 1'b0; seen_fault = 1'b0;
        if (second_start) begin
            @(negedge clk);
            vec_i = v ^ 8'h55; sp_i = sp ^ 16'h0F0F; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int k = 0; k < 400; k++) begin
            if (done_o || fault_o) begin
                seen_done = done_o; seen_fault = fault_o;
                break;
            end
            @(negedge clk);
        end
        chk(seen_done != seen_fault, "R10 single outcome", {30'd0, seen_done, seen_fault}, 32'd0);
        if (lim_fault || ip_fault) begin
            chk(seen_fault, lim_fault ? "R1 bound fault" : "R4 ip limit fault", {31'd0, seen_fault}, 32'd1);
            chk(fault_code_o == 8'd13 && fault_err_o == 16'd0, "R1 fault code",
                {8'd0, fault_code_o, fault_err_o}, {8'd0, 8'd13, 16'd0});
            if (ip_fault)
                chk(new_cs_o == last_cs, "R4 cs not loaded", {16'd0, new_cs_o}, {16'd0, last_cs});
        end else begin
            chk(seen_done, "R5 done pulse", {31'd0, seen_done}, 32'd1);
            chk(new_cs_o == csv, "R5 new cs", {16'd0, new_cs_o}, {16'd0, csv});
            chk(new_cs_base_o == ADDR_W'({csv, 4'd0}), "R5 cs base", {8'd0, new_cs_base_o}, {8'd0, 4'd0, csv, 4'd0});
            chk(new_ip_o == {16'd0, ipv}, "R5 new ip", new_ip_o, {16'd0, ipv});
            chk(new_sp_o == sp - 16'd6, "R5 new sp", {16'd0, new_sp_o}, {16'd0, sp - 16'd6});
            chk(new_flags_o == (fl & ~32'h0005_0300), "R6 flags", new_flags_o, fl & ~32'h0005_0300);
            last_cs = csv;
        end
        @(negedge clk);
        chk(!done_o && !fault_o, "R5 single-cycle pulse", {30'd0, done_o, fault_o}, 32'd0);
        chk(exp_q.size() == 0, "R3 all accesses seen", exp_q.size(), 32'd0);
        exp_q.delete();
    endtask

    initial begin
        logic [15:0] ipx;
        repeat (3) @(negedge clk);
        chk(!busy_o && !mem_req_o && !done_o && !fault_o, "R9 reset state",
            {28'd0, busy_o, mem_req_o, done_o, fault_o}, 32'd0);
        rst_n = 1'b1;
        // Plain entry, all flags set
        run_case(8'h08, 24'h000000, 16'h03FF, 32'hFFFF_FFFF, 16'h1234, 16'h0456, 16'h0100, 24'h002000, 32'h0000_FFFF, 1'b0);
        // Top vector at exact bound, offset table
        run_case(8'hFF, 24'h010000, 16'h03FF, 32'h0004_0A55, 16'hF000, 16'hFFF0, 16'h8000, 24'h030000, 32'h0000_FFFF, 1'b0);
        // Bound: 0x83 > 0x82 faults, 0x83 <= 0x83 passes
        run_case(8'h20, 24'h000400, 16'h0082, 32'h0000_0202, 16'h0700, 16'h0010, 16'h0200, 24'h001000, 32'h0000_FFFF, 1'b0);
        run_case(8'h20, 24'h000400, 16'h0083, 32'h0000_0202, 16'h0700, 16'h0010, 16'h0200, 24'h001000, 32'h0000_FFFF, 1'b0);
        // Stack wrap
        run_case(8'h10, 24'h000000, 16'hFFFF, 32'h0001_0100, 16'h2222, 16'h3333, 16'h0002, 24'h040000, 32'h0000_FFFF, 1'b0);
        // IP limit: one below faults, equal passes
        ipx = rd_fn(24'h000000 + 24'h0000C0);
        run_case(8'h30, 24'h000000, 16'h03FF, 32'h0000_0300, 16'h4444, 16'h5555, 16'h0400, 24'h050000, {16'd0, ipx} - 32'd1, 1'b0);
        run_case(8'h30, 24'h000000, 16'h03FF, 32'h0000_0300, 16'h4444, 16'h5555, 16'h0400, 24'h050000, {16'd0, ipx}, 1'b0);
        // R8 second start while busy, no stalls
        stall_mode = 1'b0;
        run_case(8'h41, 24'h002000, 16'h03FF, 32'h0004_0001, 16'h6666, 16'h7777, 16'h1000, 24'h060000, 32'h0000_FFFF, 1'b1);
        stall_mode = 1'b1;
        run_case(8'h42, 24'h002000, 16'h03FF, 32'h0000_FFFF, 16'h8888, 16'h9999, 16'h1000, 24'h060000, 32'h0000_FFFF, 1'b1);
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule